// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small register-based word store in which every word carries one tag bit that reads either empty (0) or full (1). The tag lets a producer and a consumer hand a single word to each other without a separate lock. A synchronizing store deposits a word only into an empty slot and marks it full. A synchronizing load takes a word only from a full slot and marks it empty. When the tag is in the wrong state the request does not wait. It is answered at once with a retry status, and the requester issues it again later.

Two request ports share the storage. Each port presents at most one request per cycle and receives exactly one registered response in the following cycle. Two requests to the same word in the same cycle are resolved in a fixed order: port 0 is applied first, and port 1 observes the tag and data that port 0 has just left behind. Plain loads and stores bypass the tag entirely. Two marking commands set a tag directly so that software can prepare slots before use.

Top module: `fe_tagged_mem`

## Requirements
- R1: While `rst_n` is low at a clock edge, every tag becomes empty, every word becomes zero and both response valids become low.
- R2: A request accepted in cycle N (`pX_req_valid` high) produces exactly one response with `pX_rsp_valid` high in cycle N+1. A cycle without a request produces no response.
- R3: A synchronizing store (op 3'b011) to an empty word writes `pX_req_wdata`, sets the tag to full and responds with `pX_rsp_ok` high.
- R4: A synchronizing store to a full word responds with `pX_rsp_ok` low and changes neither the data nor the tag.
- R5: A synchronizing load (op 3'b010) from a full word returns the word on `pX_rsp_rdata`, clears the tag to empty and responds ok.
- R6: A synchronizing load from an empty word responds with `pX_rsp_ok` low and read data zero, and it changes nothing. Every retry response carries zero read data.
- R7: A plain load (op 3'b000) returns the word and a plain store (op 3'b001) writes it. Both always respond ok and neither reads nor changes the tag.
- R8: The mark-empty (op 3'b100) and mark-full (op 3'b101) commands set the addressed tag to empty or full, respond ok and leave the data unchanged.
- R9: When both ports address the same word in one cycle, port 0's operation takes effect first. Port 1's tag check and read data then reflect port 0's update.
- R10: When both ports write the same word in one cycle, the word ends up holding port 1's data.
- R11: The op codes 3'b110 and 3'b111 respond with `pX_rsp_ok` low and change neither data nor tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| p0_req_valid | input | 1 | Port 0 request present |
| p0_req_op | input | 3 | Port 0 operation code |
| p0_req_addr | input | ADDR_W | Port 0 word address |
| p0_req_wdata | input | WIDTH | Port 0 store data |
| p0_rsp_valid | output | 1 | Port 0 response present |
| p0_rsp_ok | output | 1 | Port 0 completed (1) or retry (0) |
| p0_rsp_rdata | output | WIDTH | Port 0 load data, zero when nothing is returned |
| p1_req_valid | input | 1 | Port 1 request present |
| p1_req_op | input | 3 | Port 1 operation code |
| p1_req_addr | input | ADDR_W | Port 1 word address |
| p1_req_wdata | input | WIDTH | Port 1 store data |
| p1_rsp_valid | output | 1 | Port 1 response present |
| p1_rsp_ok | output | 1 | Port 1 completed (1) or retry (0) |
| p1_rsp_rdata | output | WIDTH | Port 1 load data, zero when nothing is returned |

## Verification
The assertions run on every cycle. They cover the one-cycle request-to-response relation, the zero data on retries, and the reset state. They also cover the tag effects of port 0's synchronizing and plain operations when port 1 touches another word, and the forwarding of port 0's store to port 1's synchronizing load on the same word. The bench scenarios cover the rest. These are data preservation across refused stores, the marking commands, the write order when both ports store to one word, the reverse collision in which port 0's load fails and port 1's store succeeds, and long mixed traffic on a few words checked against a sequential model.

// File: rtl/fe_pkg.sv
// Shared operation codes and the per-request action decoder for the tagged memory.
// Assumes a 3-bit operation field. Codes not listed here are treated as refused.
package fe_pkg;

    localparam logic [2:0] OP_LOAD       = 3'b000;
    localparam logic [2:0] OP_STORE      = 3'b001;
    localparam logic [2:0] OP_SYNC_LOAD  = 3'b010;
    localparam logic [2:0] OP_SYNC_STORE = 3'b011;
    localparam logic [2:0] OP_MARK_EMPTY = 3'b100;
    localparam logic [2:0] OP_MARK_FULL  = 3'b101;

    // Effect of one request on one word, given the tag that request observes.
    typedef struct packed {
        logic ok;       // request completed
        logic data_we;  // write the store data into the word
        logic tag_we;   // write tag_val into the tag
        logic tag_val;  // new tag value when tag_we
        logic rd_en;    // return the word's data
    } fe_act_t;

    // Decide the action of a request from its op code and the tag it sees.
    function automatic fe_act_t fe_decide(input logic [2:0] op, input logic tag_full);
        fe_act_t a;
        a = '0;
        case (op)
            OP_LOAD: begin
                a.ok    = 1'b1;
                a.rd_en = 1'b1;
            end
            OP_STORE: begin
                a.ok      = 1'b1;
                a.data_we = 1'b1;
            end
            OP_SYNC_LOAD: begin
                if (tag_full) begin
                    a.ok      = 1'b1;
                    a.rd_en   = 1'b1;
                    a.tag_we  = 1'b1;
                    a.tag_val = 1'b0;
                end
            end
            OP_SYNC_STORE: begin
                if (!tag_full) begin
                    a.ok      = 1'b1;
                    a.data_we = 1'b1;
                    a.tag_we  = 1'b1;
                    a.tag_val = 1'b1;
                end
            end
            OP_MARK_EMPTY: begin
                a.ok      = 1'b1;
                a.tag_we  = 1'b1;
                a.tag_val = 1'b0;
            end
            OP_MARK_FULL: begin
                a.ok      = 1'b1;
                a.tag_we  = 1'b1;
                a.tag_val = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/fe_tag_store.sv
// Tag bit array: one flop per word, 1 = full, 0 = empty.
// Two write ports; when both hit the same word the port 1 write lands last.
// Assumes DEPTH is a power of two so every address selects a word.
module fe_tag_store #(
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic              rd_tag0,
    output logic              rd_tag1,
    input  logic              wr_en0,
    input  logic [ADDR_W-1:0] wr_addr0,
    input  logic              wr_val0,
    input  logic              wr_en1,
    input  logic [ADDR_W-1:0] wr_addr1,
    input  logic              wr_val1,
    output logic [DEPTH-1:0]  tags
);

    logic [DEPTH-1:0] tag_q;

    // Clear all tags on reset, else apply port 0 then port 1 updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            if (wr_en0) tag_q[wr_addr0] <= wr_val0;
            if (wr_en1) tag_q[wr_addr1] <= wr_val1;
        end
    end

    assign rd_tag0 = tag_q[rd_addr0];
    assign rd_tag1 = tag_q[rd_addr1];
    assign tags    = tag_q;

endmodule

// File: rtl/fe_word_store.sv
// Data words held in flops, one register per word built by a generate loop.
// Two write ports with port 1 taking precedence on a same-word write.
// Two asynchronous read ports. Assumes DEPTH is a power of two.
module fe_word_store #(
    parameter  int WIDTH  = 32,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr0,
    input  logic [ADDR_W-1:0] rd_addr1,
    output logic [WIDTH-1:0]  rd_data0,
    output logic [WIDTH-1:0]  rd_data1,
    input  logic              wr_en0,
    input  logic [ADDR_W-1:0] wr_addr0,
    input  logic [WIDTH-1:0]  wr_data0,
    input  logic              wr_en1,
    input  logic [ADDR_W-1:0] wr_addr1,
    input  logic [WIDTH-1:0]  wr_data1
);

    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic hit0;
        logic hit1;
        assign hit0 = wr_en0 && (wr_addr0 == ADDR_W'(w));
        assign hit1 = wr_en1 && (wr_addr1 == ADDR_W'(w));

        // Zero on reset; port 1 data wins over port 0 on a shared write.
        always_ff @(posedge clk) begin
            if (!rst_n)    word_q[w] <= '0;
            else if (hit1) word_q[w] <= wr_data1;
            else if (hit0) word_q[w] <= wr_data0;
        end
    end

    assign rd_data0 = word_q[rd_addr0];
    assign rd_data1 = word_q[rd_addr1];

endmodule

// File: rtl/fe_port_order.sv
// Combinational resolver for the two request ports.
// Port 0 is decided against the stored tag and data. Port 1 is decided against
// the tag and data as port 0 leaves them when both address the same word, so a
// same-cycle pair behaves as port 0 followed by port 1.
// Produces write controls for the stores and the next response contents.
module fe_port_order
    import fe_pkg::*;
#(
    parameter  int WIDTH  = 32,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              req_valid0,
    input  logic [2:0]        req_op0,
    input  logic [ADDR_W-1:0] req_addr0,
    input  logic [WIDTH-1:0]  req_wdata0,
    input  logic              req_valid1,
    input  logic [2:0]        req_op1,
    input  logic [ADDR_W-1:0] req_addr1,
    input  logic [WIDTH-1:0]  req_wdata1,
    input  logic              cur_tag0,
    input  logic              cur_tag1,
    input  logic [WIDTH-1:0]  cur_data0,
    input  logic [WIDTH-1:0]  cur_data1,
    output logic              data_we0,
    output logic              data_we1,
    output logic              tag_we0,
    output logic              tag_we1,
    output logic              tag_val0,
    output logic              tag_val1,
    output logic              rsp_ok0,
    output logic              rsp_ok1,
    output logic [WIDTH-1:0]  rsp_data0,
    output logic [WIDTH-1:0]  rsp_data1
);

    fe_act_t          act0;
    fe_act_t          act1;
    logic             same_word;
    logic             seen_tag1;
    logic [WIDTH-1:0] seen_data1;

    // Port 0 acts on the stored state.
    always_comb begin
        act0 = req_valid0 ? fe_decide(req_op0, cur_tag0) : '0;
    end

    assign same_word = req_valid0 && req_valid1 && (req_addr0 == req_addr1);

    // Port 1 sees port 0's tag and data effects on a shared word.
    always_comb begin
        seen_tag1  = (same_word && act0.tag_we)  ? act0.tag_val : cur_tag1;
        seen_data1 = (same_word && act0.data_we) ? req_wdata0   : cur_data1;
        act1       = req_valid1 ? fe_decide(req_op1, seen_tag1) : '0;
    end

    // Drive storage updates and response payloads from both actions.
    always_comb begin
        data_we0  = act0.data_we;
        data_we1  = act1.data_we;
        tag_we0   = act0.tag_we;
        tag_we1   = act1.tag_we;
        tag_val0  = act0.tag_val;
        tag_val1  = act1.tag_val;
        rsp_ok0   = act0.ok;
        rsp_ok1   = act1.ok;
        rsp_data0 = act0.rd_en ? cur_data0  : '0;
        rsp_data1 = act1.rd_en ? seen_data1 : '0;
    end

endmodule

// File: rtl/fe_rsp_stage.sv
// One response register per port: valid, completion status and read data,
// all captured one cycle after the request. Cleared by synchronous reset.
module fe_rsp_stage #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ok,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic             out_ok,
    output logic [WIDTH-1:0] out_data
);

    // Register the response fields; reset them all to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ok    <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_ok    <= in_ok;
            out_data  <= in_data;
        end
    end

endmodule

// File: rtl/fe_tagged_mem.sv
// Two-port word memory with a full/empty tag per word.
// Every request is answered one cycle later with ok or retry. Same-cycle
// requests to one word are ordered port 0 then port 1. Tag check, tag update
// and data access of one request happen in the same clock edge.
// Assumes DEPTH is a power of two.
module fe_tagged_mem #(
    parameter  int WIDTH  = 32,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_req_valid,
    input  logic [2:0]        p0_req_op,
    input  logic [ADDR_W-1:0] p0_req_addr,
    input  logic [WIDTH-1:0]  p0_req_wdata,
    output logic              p0_rsp_valid,
    output logic              p0_rsp_ok,
    output logic [WIDTH-1:0]  p0_rsp_rdata,
    input  logic              p1_req_valid,
    input  logic [2:0]        p1_req_op,
    input  logic [ADDR_W-1:0] p1_req_addr,
    input  logic [WIDTH-1:0]  p1_req_wdata,
    output logic              p1_rsp_valid,
    output logic              p1_rsp_ok,
    output logic [WIDTH-1:0]  p1_rsp_rdata
);

    localparam int NPORT = 2;

    logic             cur_tag0, cur_tag1;
    logic [WIDTH-1:0] cur_data0, cur_data1;
    logic             data_we0, data_we1;
    logic             tag_we0, tag_we1;
    logic             tag_val0, tag_val1;
    logic [DEPTH-1:0] tag_vec;

    logic             nxt_valid [NPORT];
    logic             nxt_ok    [NPORT];
    logic [WIDTH-1:0] nxt_data  [NPORT];
    logic             rsp_valid [NPORT];
    logic             rsp_ok    [NPORT];
    logic [WIDTH-1:0] rsp_data  [NPORT];

    fe_tag_store #(.DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr0 (p0_req_addr),
        .rd_addr1 (p1_req_addr),
        .rd_tag0  (cur_tag0),
        .rd_tag1  (cur_tag1),
        .wr_en0   (tag_we0),
        .wr_addr0 (p0_req_addr),
        .wr_val0  (tag_val0),
        .wr_en1   (tag_we1),
        .wr_addr1 (p1_req_addr),
        .wr_val1  (tag_val1),
        .tags     (tag_vec)
    );

    fe_word_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr0 (p0_req_addr),
        .rd_addr1 (p1_req_addr),
        .rd_data0 (cur_data0),
        .rd_data1 (cur_data1),
        .wr_en0   (data_we0),
        .wr_addr0 (p0_req_addr),
        .wr_data0 (p0_req_wdata),
        .wr_en1   (data_we1),
        .wr_addr1 (p1_req_addr),
        .wr_data1 (p1_req_wdata)
    );

    fe_port_order #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_order (
        .req_valid0 (p0_req_valid),
        .req_op0    (p0_req_op),
        .req_addr0  (p0_req_addr),
        .req_wdata0 (p0_req_wdata),
        .req_valid1 (p1_req_valid),
        .req_op1    (p1_req_op),
        .req_addr1  (p1_req_addr),
        .req_wdata1 (p1_req_wdata),
        .cur_tag0   (cur_tag0),
        .cur_tag1   (cur_tag1),
        .cur_data0  (cur_data0),
        .cur_data1  (cur_data1),
        .data_we0   (data_we0),
        .data_we1   (data_we1),
        .tag_we0    (tag_we0),
        .tag_we1    (tag_we1),
        .tag_val0   (tag_val0),
        .tag_val1   (tag_val1),
        .rsp_ok0    (nxt_ok[0]),
        .rsp_ok1    (nxt_ok[1]),
        .rsp_data0  (nxt_data[0]),
        .rsp_data1  (nxt_data[1])
    );

    assign nxt_valid[0] = p0_req_valid;
    assign nxt_valid[1] = p1_req_valid;

    for (genvar p = 0; p < NPORT; p++) begin : g_rsp
        fe_rsp_stage #(.WIDTH(WIDTH)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (nxt_valid[p]),
            .in_ok     (nxt_ok[p]),
            .in_data   (nxt_data[p]),
            .out_valid (rsp_valid[p]),
            .out_ok    (rsp_ok[p]),
            .out_data  (rsp_data[p])
        );
    end

    assign p0_rsp_valid = rsp_valid[0];
    assign p0_rsp_ok    = rsp_ok[0];
    assign p0_rsp_rdata = rsp_data[0];
    assign p1_rsp_valid = rsp_valid[1];
    assign p1_rsp_ok    = rsp_ok[1];
    assign p1_rsp_rdata = rsp_data[1];

endmodule

// File: rtl/fe_tagged_mem_chk.sv
// Property checker for fe_tagged_mem, attached by bind below.
// Observes the ports and the tag vector that the tag store drives.
module fe_tagged_mem_chk #(
    parameter  int WIDTH  = 32,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p0_req_valid,
    input logic [2:0]        p0_req_op,
    input logic [ADDR_W-1:0] p0_req_addr,
    input logic [WIDTH-1:0]  p0_req_wdata,
    input logic              p0_rsp_valid,
    input logic              p0_rsp_ok,
    input logic [WIDTH-1:0]  p0_rsp_rdata,
    input logic              p1_req_valid,
    input logic [2:0]        p1_req_op,
    input logic [ADDR_W-1:0] p1_req_addr,
    input logic              p1_rsp_valid,
    input logic              p1_rsp_ok,
    input logic [WIDTH-1:0]  p1_rsp_rdata,
    input logic [DEPTH-1:0]  tags
);

    logic p1_same;
    assign p1_same = p1_req_valid && (p1_req_addr == p0_req_addr);

    // R1: reset empties every tag and silences both responses.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (tags == '0) && !p0_rsp_valid && !p1_rsp_valid);

    // R2: one response per request, one cycle later.
    a_r2_rsp_p0: assert property (@(posedge clk) disable iff (!rst_n)
        p0_req_valid |=> p0_rsp_valid);
    a_r2_rsp_p1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_req_valid |=> p1_rsp_valid);
    a_r2_quiet_p0: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_req_valid |=> !p0_rsp_valid);
    a_r2_quiet_p1: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_req_valid |=> !p1_rsp_valid);

    // R3: port 0 synchronizing store to an empty word fills it.
    a_r3_sstore_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op == 3'b011 && !tags[p0_req_addr] && !p1_same)
        |=> p0_rsp_ok && tags[$past(p0_req_addr)]);

    // R4: port 0 synchronizing store to a full word is refused.
    a_r4_sstore_full_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op == 3'b011 && tags[p0_req_addr])
        |=> !p0_rsp_ok);

    // R5: port 0 synchronizing load from a full word drains it.
    a_r5_sload_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op == 3'b010 && tags[p0_req_addr] && !p1_same)
        |=> p0_rsp_ok && !tags[$past(p0_req_addr)]);

    // R6: a retry response always carries zero data.
    a_r6_retry_zero_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rsp_valid && !p0_rsp_ok) |-> (p0_rsp_rdata == '0));
    a_r6_retry_zero_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_rsp_valid && !p1_rsp_ok) |-> (p1_rsp_rdata == '0));

    // R7: plain access on port 0 completes and leaves its tag alone.
    a_r7_plain_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op[2:1] == 2'b00 && !p1_same)
        |=> p0_rsp_ok && (tags[$past(p0_req_addr)] == $past(tags[p0_req_addr])));

    // R9: port 1 synchronizing load sees port 0's same-cycle synchronizing store.
    a_r9_port1_sees_port0: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op == 3'b011 && !tags[p0_req_addr]
         && p1_same && p1_req_op == 3'b010)
        |=> p1_rsp_ok && (p1_rsp_rdata == $past(p0_req_wdata)));

    // R11: undefined op codes are refused.
    a_r11_undef_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_op[2:1] == 2'b11) |=> !p0_rsp_ok);

endmodule

bind fe_tagged_mem fe_tagged_mem_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .p0_req_valid (p0_req_valid),
    .p0_req_op    (p0_req_op),
    .p0_req_addr  (p0_req_addr),
    .p0_req_wdata (p0_req_wdata),
    .p0_rsp_valid (p0_rsp_valid),
    .p0_rsp_ok    (p0_rsp_ok),
    .p0_rsp_rdata (p0_rsp_rdata),
    .p1_req_valid (p1_req_valid),
    .p1_req_op    (p1_req_op),
    .p1_req_addr  (p1_req_addr),
    .p1_rsp_valid (p1_rsp_valid),
    .p1_rsp_ok    (p1_rsp_ok),
    .p1_rsp_rdata (p1_rsp_rdata),
    .tags         (tag_vec)
);

// File: tb/sim_fe_tagged_mem.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each request in port order and queues
// the expected response; the monitor compares after every rising edge.
module sim_fe_tagged_mem;

    localparam int W  = 32;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          v0 = 0, v1 = 0;
    logic [2:0]    o0 = 0, o1 = 0;
    logic [AW-1:0] a0 = 0, a1 = 0;
    logic [W-1:0]  d0 = 0, d1 = 0;
    logic          rv0, rv1, rk0, rk1;
    logic [W-1:0]  rd0, rd1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic         vld;
        logic         ok;
        logic [W-1:0] dat;
        string        lab;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    logic         mtag [D];
    logic [W-1:0] mdat [D];

    always #5 clk = ~clk;

    fe_tagged_mem #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n),
        .p0_req_valid(v0), .p0_req_op(o0), .p0_req_addr(a0), .p0_req_wdata(d0),
        .p0_rsp_valid(rv0), .p0_rsp_ok(rk0), .p0_rsp_rdata(rd0),
        .p1_req_valid(v1), .p1_req_op(o1), .p1_req_addr(a1), .p1_req_wdata(d1),
        .p1_rsp_valid(rv1), .p1_rsp_ok(rk1), .p1_rsp_rdata(rd1)
    );

    // Spec model of one request applied to the current model state.
    task automatic model(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [W-1:0] d, input string lab, output exp_t e);
        e.vld = v; e.ok = 1'b0; e.dat = '0; e.lab = lab;
        if (v) begin
            case (op)
                3'd0: begin e.ok = 1; e.dat = mdat[a]; end
                3'd1: begin e.ok = 1; mdat[a] = d; end
                3'd2: if (mtag[a]) begin e.ok = 1; e.dat = mdat[a]; mtag[a] = 0; end
                3'd3: if (!mtag[a]) begin e.ok = 1; mdat[a] = d; mtag[a] = 1; end
                3'd4: begin e.ok = 1; mtag[a] = 0; end
                3'd5: begin e.ok = 1; mtag[a] = 1; end
                default: e.ok = 0;
            endcase
        end
    endtask

    // Drive one cycle of requests on both ports and queue the expectations.
    task automatic step(input logic pv0, input logic [2:0] po0, input logic [AW-1:0] pa0,
                        input logic [W-1:0] pd0, input logic pv1, input logic [2:0] po1,
                        input logic [AW-1:0] pa1, input logic [W-1:0] pd1, input string lab);
        exp_t e0, e1;
        model(pv0, po0, pa0, pd0, lab, e0);
        model(pv1, po1, pa1, pd1, lab, e1);
        q0.push_back(e0);
        q1.push_back(e1);
        v0 = pv0; o0 = po0; a0 = pa0; d0 = pd0;
        v1 = pv1; o1 = po1; a1 = pa1; d1 = pd1;
        @(negedge clk);
    endtask

    task automatic cmp(input int port, input exp_t e, input logic v, input logic k,
                       input logic [W-1:0] dat);
        checks++;
        if (v !== e.vld || (e.vld && (k !== e.ok || dat !== e.dat))) begin
            fails++;
            $display("FAIL %s port%0d: got v=%0b ok=%0b data=%h, expected v=%0b ok=%0b data=%h",
                     e.lab, port, v, k, dat, e.vld, e.ok, e.dat);
        end
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (q0.size() > 0) cmp(0, q0.pop_front(), rv0, rk0, rd0);
                else if (rv0) begin fails++; $display("FAIL R2 port0: got unexpected response, expected none"); end
                if (q1.size() > 0) cmp(1, q1.pop_front(), rv1, rk1, rd1);
                else if (rv1) begin fails++; $display("FAIL R2 port1: got unexpected response, expected none"); end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < D; i++) begin mtag[i] = 0; mdat[i] = '0; end
        repeat (3) @(negedge clk);
        checks++;
        if (rv0 !== 1'b0 || rv1 !== 1'b0) begin
            fails++;
            $display("FAIL R1: got rsp_valid %0b/%0b, expected 0/0", rv0, rv1);
        end
        rst_n = 1'b1;

        // R1: tags empty and words zero after reset.
        step(1, 3'd2, 4'd0, 0, 1, 3'd2, 4'd9, 0, "R1");
        step(1, 3'd0, 4'd5, 0, 1, 3'd0, 4'd15, 0, "R1");
        // R2: idle cycle gives no response.
        step(0, 3'd0, 4'd0, 0, 0, 3'd0, 4'd0, 0, "R2");
        // R6: synchronizing load on empty word with data present.
        step(1, 3'd1, 4'd3, 32'hAAAA_0003, 0, 0, 0, 0, "R7");
        step(1, 3'd2, 4'd3, 0, 0, 0, 0, 0, "R6");
        // R3 then R4: fill, then a refused second fill.
        step(1, 3'd3, 4'd3, 32'h1234_5678, 0, 0, 0, 0, "R3");
        step(1, 3'd3, 4'd3, 32'hDEAD_BEEF, 1, 3'd3, 4'd3, 32'hFEED_0001, "R4");
        step(1, 3'd0, 4'd3, 0, 0, 0, 0, 0, "R4");
        // R5: drain, then a second drain is refused.
        step(0, 0, 0, 0, 1, 3'd2, 4'd3, 0, "R5");
        step(1, 3'd2, 4'd3, 0, 0, 0, 0, 0, "R6");
        // R7: plain store to an empty word does not fill it.
        step(1, 3'd1, 4'd4, 32'h0000_0044, 0, 0, 0, 0, "R7");
        step(1, 3'd2, 4'd4, 0, 0, 0, 0, 0, "R7");
        // R8: mark full keeps data; drain then returns it.
        step(1, 3'd5, 4'd4, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
        step(1, 3'd2, 4'd4, 0, 0, 0, 0, 0, "R8");
        // R7: plain load on a full word leaves it full.
        step(0, 0, 0, 0, 1, 3'd5, 4'd6, 0, "R8");
        step(1, 3'd0, 4'd6, 0, 0, 0, 0, 0, "R7");
        step(1, 3'd3, 4'd6, 32'h66, 0, 0, 0, 0, "R7");
        step(1, 3'd4, 4'd6, 0, 0, 0, 0, 0, "R8");
        step(1, 3'd3, 4'd6, 32'h67, 0, 0, 0, 0, "R8");
        // R9: same word, port 0 fills and port 1 drains in one cycle.
        step(1, 3'd3, 4'd5, 32'hC0FF_EE00, 1, 3'd2, 4'd5, 0, "R9");
        // R9: reverse order, port 0 drain refused, port 1 fill succeeds.
        step(1, 3'd2, 4'd5, 0, 1, 3'd3, 4'd5, 32'h0BAD_F00D, "R9");
        step(1, 3'd2, 4'd5, 0, 1, 3'd2, 4'd5, 0, "R9");
        // R10: both ports write one word; port 1 data remains.
        step(1, 3'd1, 4'd7, 32'h1111_1111, 1, 3'd1, 4'd7, 32'h2222_2222, "R10");
        step(1, 3'd0, 4'd7, 0, 1, 3'd0, 4'd7, 0, "R10");
        // R11: undefined ops refused, no effect.
        step(1, 3'd6, 4'd7, 32'h9, 1, 3'd7, 4'd8, 32'h9, "R11");
        step(1, 3'd2, 4'd8, 0, 1, 3'd0, 4'd7, 0, "R11");

        // Mixed traffic on four words to force collisions.
        for (int n = 0; n < 400; n++) begin
            step(1'($urandom), 3'($urandom), AW'($urandom % 4), $urandom,
                 1'($urandom), 3'($urandom), AW'($urandom % 4), $urandom, "R9");
        end

        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule